// File: doc/BRIEF.md
# Proportional Text Line Layout Engine

This block lays out one line of proportional text. It walks a string of 8-bit character codes from a start index up to a last index. The codes are read from a 16-bit word-addressed memory. For each character it looks up two-bit attribute flags, a pixel width, a glyph descriptor word and a metric width in font tables held in the same memory. It then advances a pixel position and a metric position. The walk ends when the index passes the last index, when the next character would cross an unsigned metric margin, or when a stop character is reached. Pad characters are widened by a space amount. A signed count spreads one extra pixel over the first pads.

There are three modes. Display mode issues a glyph-copy request for every character and waits for the copy engine to acknowledge it. Format mode only measures the line, and pads gain no space in this mode. Resolve mode writes the pixel position of each character into a coordinate array. On completion the block reports a status together with the final index, both positions and the count, so an interrupted line can be resumed from the character where it stopped.

Top module: `text_layout_engine`

## Requirements
- R1: After reset `done_o`, `mem_req_o` and `blit_req_o` are low. The memory port and the copy request are never active in the same cycle.
- R2: At the top of each character step, if `last - index` (16-bit, taken as signed) is negative, the block finishes with status 0 and makes no further memory access.
- R3: The character is read from word `text_base + (index >> 1)`. An even index takes bits 15:8 and an odd index takes bits 7:0.
- R4: Flags come from word `flags_base + (char >> 3)`. A character whose low three bits are n uses bits `15-2n` (pad) and `14-2n` (stop). A stop character ends the walk with status 2, before any width is applied or any copy is requested.
- R5: The pixel width is read from word `font_base + 512 + (char >> 1)`, with the byte chosen by the parity of the character (even gives bits 15:8). The descriptor word is at `font_base + 2*char` and the metric width is at `font_base + 2*char + 1`.
- R6: The candidate metric position is `(metric + metric_width) mod 2^16`. If it is unsigned-greater than the margin, the block finishes with status 1, and the index, positions and count keep their values from before this character.
- R7: In display mode a copy request carries source `font_base + 640 + desc[13:0]` and width `pixel_width + desc[15] + desc[14]`. Its destination is `dst_base + (p >> 4)` and bit `p & 15`, where `p = pixel - desc[15]`.
- R8: A copy request stays asserted with stable fields until `copy_done_i`. The character is not finished before that.
- R9: A finished character advances the pixel position by its pixel width, sets the metric position to the candidate value and increments the index.
- R10: For a pad character the count is incremented. Outside format mode the pixel position also gains `space`, plus 1 more when the count was negative before the increment.
- R11: In resolve mode the current pixel position is written to word `coord_base + index` before the character is fetched.
- R12: Completion is a one-cycle `done_o` pulse. Status, index, pixel position, metric position and count are valid with it and are held until the next start.
- R13: A memory request keeps its address and direction until `mem_valid_i` is seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (taken when idle) |
| mode_i | input | 2 | 0 display, 1 format, 2 resolve |
| index_i | input | 16 | Start character index |
| last_i | input | 16 | Last character index |
| pix_pos_i | input | 16 | Start pixel position |
| met_pos_i | input | 16 | Start metric position |
| count_i | input | 16 | Signed justification count |
| margin_i | input | 16 | Unsigned metric margin |
| space_i | input | 16 | Pixels added to pad characters |
| text_base_i | input | 16 | Word address of the text string |
| flags_base_i | input | 16 | Word address of the flag table |
| font_base_i | input | 16 | Word address of the font body |
| coord_base_i | input | 16 | Word address of the coordinate array |
| dst_base_i | input | 16 | Destination word base for copies |
| done_o | output | 1 | Completion pulse |
| status_o | output | 2 | 0 end of text, 1 margin, 2 stop character |
| index_o | output | 16 | Final index |
| pix_pos_o | output | 16 | Final pixel position |
| met_pos_o | output | 16 | Final metric position |
| count_o | output | 16 | Final count |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Write data |
| mem_valid_i | input | 1 | Memory completes the request this cycle |
| mem_rdata_i | input | 16 | Read data, valid with `mem_valid_i` |
| blit_req_o | output | 1 | Glyph copy request |
| blit_src_o | output | 16 | Copy source word address |
| blit_dst_word_o | output | 16 | Copy destination word address |
| blit_dst_bit_o | output | 4 | Copy destination bit offset |
| blit_width_o | output | 16 | Copy width in pixels |
| copy_done_i | input | 1 | Copy engine finished |

## Verification
A wrong character byte or flag field shows up within a few memory transactions. It either alters the next copy descriptor or coordinate write, or it ends the walk with the wrong status, and the next request is compared to the reference model as soon as it appears. A wrong position or count register does not show in display mode until the following copy request or until the final outputs. In resolve mode it shows one character later, in the next coordinate write. A stuck state machine shows as a request held without end or as a missing `done_o` pulse.

// File: rtl/tle_pkg.sv
package tle_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_TOP, ST_COORD, ST_TEXT, ST_FLAG, ST_PWID,
    ST_ENT0, ST_ENT1, ST_BLIT, ST_ADV, ST_DONE
  } tle_state_e;

  localparam logic [1:0] STAT_END    = 2'd0;
  localparam logic [1:0] STAT_MARGIN = 2'd1;
  localparam logic [1:0] STAT_STOP   = 2'd2;

  localparam logic [1:0] MODE_DISPLAY = 2'd0;
  localparam logic [1:0] MODE_RESOLVE = 2'd2;
endpackage

// File: rtl/tle_byte_pick.sv
module tle_byte_pick #(
  parameter int DW = 16,
  localparam int CW = DW / 2
) (
  input  logic [DW-1:0] word_i,
  input  logic          odd_i,
  output logic [CW-1:0] byte_o
);
  assign byte_o = odd_i ? word_i[CW-1:0] : word_i[DW-1:CW];
endmodule

// File: rtl/tle_flag_pick.sv
module tle_flag_pick #(
  parameter int DW = 16,
  localparam int NF = DW / 2,
  localparam int SW = $clog2(NF)
) (
  input  logic [DW-1:0] word_i,
  input  logic [SW-1:0] sel_i,
  output logic          stop_o,
  output logic          pad_o
);
  logic [1:0] fld [NF];

  // field 0 sits in the top two bits
  for (genvar k = 0; k < NF; k++) begin : g_fld
    assign fld[k] = word_i[DW-1-2*k -: 2];
  end

  assign stop_o = fld[sel_i][0];
  assign pad_o  = fld[sel_i][1];
endmodule

// File: rtl/tle_glyph_calc.sv
module tle_glyph_calc #(
  parameter int DW        = 16,
  parameter int GLYPH_OFS = 640,
  localparam int CW = DW / 2,
  localparam int BW = $clog2(DW),
  localparam int OW = DW - 2
) (
  input  logic [DW-1:0] font_base_i,
  input  logic [DW-1:0] dst_base_i,
  input  logic [DW-1:0] pix_i,
  input  logic [DW-1:0] entry_i,
  input  logic [CW-1:0] pwid_i,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_word_o,
  output logic [BW-1:0] dst_bit_o,
  output logic [DW-1:0] width_o
);
  localparam logic [DW-1:0] GOFS = GLYPH_OFS[DW-1:0];

  logic          lk, rk;
  logic [DW-1:0] dst_pos;

  assign lk         = entry_i[DW-1];
  assign rk         = entry_i[DW-2];
  assign src_o      = font_base_i + GOFS + {2'b00, entry_i[OW-1:0]};
  assign dst_pos    = pix_i - {{(DW-1){1'b0}}, lk};
  assign dst_word_o = dst_base_i + (dst_pos >> BW);
  assign dst_bit_o  = dst_pos[BW-1:0];
  assign width_o    = {{(DW-CW){1'b0}}, pwid_i} + {{(DW-1){1'b0}}, lk}
                    + {{(DW-1){1'b0}}, rk};
endmodule

// File: rtl/tle_advance.sv
module tle_advance #(
  parameter int DW = 16,
  localparam int CW = DW / 2
) (
  input  logic [DW-1:0] pix_i,
  input  logic [CW-1:0] pwid_i,
  input  logic          pad_i,
  input  logic          fmt_i,
  input  logic [DW-1:0] count_i,
  input  logic [DW-1:0] space_i,
  output logic [DW-1:0] pix_o,
  output logic [DW-1:0] count_o
);
  logic [DW-1:0] base;

  assign base = pix_i + {{(DW-CW){1'b0}}, pwid_i};

  always_comb begin
    pix_o   = base;
    count_o = count_i;
    if (pad_i) begin
      count_o = count_i + {{(DW-1){1'b0}}, 1'b1};
      // negative count earns one extra pixel
      if (!fmt_i) pix_o = base + space_i + {{(DW-1){1'b0}}, count_i[DW-1]};
    end
  end
endmodule

// File: rtl/text_layout_engine.sv
module text_layout_engine
  import tle_pkg::*;
#(
  parameter int DW        = 16,
  parameter int WIDTH_OFS = 512,
  parameter int GLYPH_OFS = 640,
  localparam int CW = DW / 2,
  localparam int SW = $clog2(DW / 2),
  localparam int BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] index_i,
  input  logic [DW-1:0] last_i,
  input  logic [DW-1:0] pix_pos_i,
  input  logic [DW-1:0] met_pos_i,
  input  logic [DW-1:0] count_i,
  input  logic [DW-1:0] margin_i,
  input  logic [DW-1:0] space_i,
  input  logic [DW-1:0] text_base_i,
  input  logic [DW-1:0] flags_base_i,
  input  logic [DW-1:0] font_base_i,
  input  logic [DW-1:0] coord_base_i,
  input  logic [DW-1:0] dst_base_i,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic [DW-1:0] index_o,
  output logic [DW-1:0] pix_pos_o,
  output logic [DW-1:0] met_pos_o,
  output logic [DW-1:0] count_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          blit_req_o,
  output logic [DW-1:0] blit_src_o,
  output logic [DW-1:0] blit_dst_word_o,
  output logic [BW-1:0] blit_dst_bit_o,
  output logic [DW-1:0] blit_width_o,
  input  logic          copy_done_i
);
  localparam logic [DW-1:0] WOFS = WIDTH_OFS[DW-1:0];

  tle_state_e    state_q;
  logic [1:0]    mode_q, status_q;
  logic [DW-1:0] idx_q, last_q, pix_q, met_q, cnt_q, margin_q, space_q;
  logic [DW-1:0] text_q, flags_q, font_q, coord_q, dst_q;
  logic [DW-1:0] ent0_q, met_new_q;
  logic [CW-1:0] ch_q, pwid_q;
  logic          pad_q;

  logic [DW-1:0] ch_ext, diff, met_sum, pix_next, cnt_next;
  logic [CW-1:0] byte_w;
  logic          stop_w, pad_w;

  assign ch_ext  = {{(DW-CW){1'b0}}, ch_q};
  assign diff    = last_q - idx_q;
  assign met_sum = met_q + mem_rdata_i;

  tle_byte_pick #(.DW(DW)) u_byte (
    .word_i (mem_rdata_i),
    .odd_i  ((state_q == ST_TEXT) ? idx_q[0] : ch_q[0]),
    .byte_o (byte_w)
  );

  tle_flag_pick #(.DW(DW)) u_flag (
    .word_i (mem_rdata_i),
    .sel_i  (ch_q[SW-1:0]),
    .stop_o (stop_w),
    .pad_o  (pad_w)
  );

  tle_glyph_calc #(.DW(DW), .GLYPH_OFS(GLYPH_OFS)) u_glyph (
    .font_base_i (font_q),
    .dst_base_i  (dst_q),
    .pix_i       (pix_q),
    .entry_i     (ent0_q),
    .pwid_i      (pwid_q),
    .src_o       (blit_src_o),
    .dst_word_o  (blit_dst_word_o),
    .dst_bit_o   (blit_dst_bit_o),
    .width_o     (blit_width_o)
  );

  tle_advance #(.DW(DW)) u_adv (
    .pix_i   (pix_q),
    .pwid_i  (pwid_q),
    .pad_i   (pad_q),
    .fmt_i   (mode_q[0]),
    .count_i (cnt_q),
    .space_i (space_q),
    .pix_o   (pix_next),
    .count_o (cnt_next)
  );

  always_comb begin
    unique case (state_q)
      ST_COORD: mem_addr_o = coord_q + idx_q;
      ST_TEXT:  mem_addr_o = text_q + (idx_q >> 1);
      ST_FLAG:  mem_addr_o = flags_q + (ch_ext >> SW);
      ST_PWID:  mem_addr_o = font_q + WOFS + (ch_ext >> 1);
      ST_ENT0:  mem_addr_o = font_q + (ch_ext << 1);
      ST_ENT1:  mem_addr_o = font_q + (ch_ext << 1) + {{(DW-1){1'b0}}, 1'b1};
      default:  mem_addr_o = '0;
    endcase
  end

  assign mem_req_o   = state_q inside {ST_COORD, ST_TEXT, ST_FLAG, ST_PWID, ST_ENT0, ST_ENT1};
  assign mem_we_o    = state_q == ST_COORD;
  assign mem_wdata_o = pix_q;
  assign blit_req_o  = state_q == ST_BLIT;
  assign done_o      = state_q == ST_DONE;
  assign status_o    = status_q;
  assign index_o     = idx_q;
  assign pix_pos_o   = pix_q;
  assign met_pos_o   = met_q;
  assign count_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q <= '0; status_q <= STAT_END;
      idx_q <= '0; last_q <= '0; pix_q <= '0; met_q <= '0; cnt_q <= '0;
      margin_q <= '0; space_q <= '0;
      text_q <= '0; flags_q <= '0; font_q <= '0; coord_q <= '0; dst_q <= '0;
      ent0_q <= '0; met_new_q <= '0; ch_q <= '0; pwid_q <= '0; pad_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q <= mode_i; idx_q <= index_i; last_q <= last_i;
          pix_q <= pix_pos_i; met_q <= met_pos_i; cnt_q <= count_i;
          margin_q <= margin_i; space_q <= space_i;
          text_q <= text_base_i; flags_q <= flags_base_i; font_q <= font_base_i;
          coord_q <= coord_base_i; dst_q <= dst_base_i;
          state_q <= ST_TOP;
        end
        ST_TOP: if (diff[DW-1]) begin
          status_q <= STAT_END; state_q <= ST_DONE;
        end else begin
          state_q <= (mode_q == MODE_RESOLVE) ? ST_COORD : ST_TEXT;
        end
        ST_COORD: if (mem_valid_i) state_q <= ST_TEXT;
        ST_TEXT: if (mem_valid_i) begin
          ch_q <= byte_w; state_q <= ST_FLAG;
        end
        ST_FLAG: if (mem_valid_i) begin
          if (stop_w) begin
            status_q <= STAT_STOP; state_q <= ST_DONE;
          end else begin
            pad_q <= pad_w; state_q <= ST_PWID;
          end
        end
        ST_PWID: if (mem_valid_i) begin
          pwid_q <= byte_w; state_q <= ST_ENT0;
        end
        ST_ENT0: if (mem_valid_i) begin
          ent0_q <= mem_rdata_i; state_q <= ST_ENT1;
        end
        ST_ENT1: if (mem_valid_i) begin
          if (met_sum > margin_q) begin
            status_q <= STAT_MARGIN; state_q <= ST_DONE;
          end else begin
            met_new_q <= met_sum;
            state_q <= (mode_q == MODE_DISPLAY) ? ST_BLIT : ST_ADV;
          end
        end
        ST_BLIT: if (copy_done_i) state_q <= ST_ADV;
        ST_ADV: begin
          pix_q <= pix_next; cnt_q <= cnt_next; met_q <= met_new_q;
          idx_q <= idx_q + {{(DW-1){1'b0}}, 1'b1};
          state_q <= ST_TOP;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_port_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && blit_req_o));

  assert_req_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_blit_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blit_req_o && !copy_done_i |=> blit_req_o && $stable(blit_src_o)
                                   && $stable(blit_dst_word_o) && $stable(blit_width_o));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !mem_req_o && $stable(index_o) && $stable(pix_pos_o));

  assert_write_mode_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o && mode_q == MODE_RESOLVE);
endmodule

// File: tb/text_layout_engine_tb_top.sv
`timescale 1ns/1ps
module text_layout_engine_tb_top;
  localparam int TB = 'h040, FLB = 'h400, FB = 'h100, CB = 'h600, DB = 'h2000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, done, mem_req, mem_we, mem_valid, blit_req, copy_done;
  logic [1:0] mode, status;
  logic [15:0] idx_in, last_in, pix_in, met_in, cnt_in, margin_in, space_in;
  logic [15:0] idx_out, pix_out, met_out, cnt_out;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, b_src, b_dw, b_w;
  logic [3:0]  b_bit;
  logic [15:0] mem [0:4095];

  int errors = 0, checks = 0, cyc = 0;
  int q_wa[$], q_wd[$], q_bs[$], q_bd[$], q_bb[$], q_bw[$];
  int e_stat, e_idx, e_pix, e_met, e_cnt;
  int wcnt = 0, bcnt = 0, req_addr = 0;
  int cap_s, cap_d;

  text_layout_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .index_i(idx_in), .last_i(last_in), .pix_pos_i(pix_in), .met_pos_i(met_in),
    .count_i(cnt_in), .margin_i(margin_in), .space_i(space_in),
    .text_base_i(16'(TB)), .flags_base_i(16'(FLB)), .font_base_i(16'(FB)),
    .coord_base_i(16'(CB)), .dst_base_i(16'(DB)),
    .done_o(done), .status_o(status), .index_o(idx_out), .pix_pos_o(pix_out),
    .met_pos_o(met_out), .count_o(cnt_out),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .blit_req_o(blit_req), .blit_src_o(b_src), .blit_dst_word_o(b_dw),
    .blit_dst_bit_o(b_bit), .blit_width_o(b_w), .copy_done_i(copy_done)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int rd(input int a);
    return int'(mem[a & 'hFFF]);
  endfunction

  function automatic int pwf(input int c);
    return (c * 7) % 13 + 3;
  endfunction

  task automatic set_flag(input int c, input int bits);
    int a = FLB + (c >> 3);
    int sh = 14 - 2 * (c & 7);
    mem[a] = 16'((rd(a) & ~(3 << sh)) | (bits << sh));
  endtask

  task automatic model(input int md, input int idx, input int last, input int pix,
                       input int met, input int cnt, input int margin, input int space);
    int i, p, m, c, w, ch, fw, fld, ww, pw, e0, e1, ns, lk, rk, dp, guard;
    i = idx; p = pix; m = met; c = cnt & 'hFFFF; e_stat = 0; guard = 0;
    while (guard < 1000) begin
      guard++;
      if ((((last - i) & 'hFFFF) & 'h8000) != 0) begin e_stat = 0; break; end
      if (md == 2) begin q_wa.push_back((CB + i) & 'hFFFF); q_wd.push_back(p); end
      w = rd(TB + (i >> 1));
      ch = (i % 2 == 0) ? (w >> 8) : (w & 'hFF);
      fw = rd(FLB + (ch >> 3));
      fld = (fw >> (14 - 2 * (ch & 7))) & 3;
      if ((fld & 1) != 0) begin e_stat = 2; break; end
      ww = rd(FB + 512 + (ch >> 1));
      pw = (ch % 2 == 0) ? (ww >> 8) : (ww & 'hFF);
      e0 = rd(FB + 2 * ch); e1 = rd(FB + 2 * ch + 1);
      ns = (m + e1) & 'hFFFF;
      if (ns > margin) begin e_stat = 1; break; end
      if (md == 0) begin
        lk = e0 >> 15; rk = (e0 >> 14) & 1; dp = (p - lk) & 'hFFFF;
        q_bs.push_back((FB + 640 + (e0 & 'h3FFF)) & 'hFFFF);
        q_bd.push_back((DB + (dp >> 4)) & 'hFFFF);
        q_bb.push_back(dp & 15);
        q_bw.push_back(pw + lk + rk);
      end
      p = (p + pw) & 'hFFFF;
      if ((fld & 2) != 0) begin
        if (md != 1) p = (p + space + (((c & 'h8000) != 0) ? 1 : 0)) & 'hFFFF;
        c = (c + 1) & 'hFFFF;
      end
      m = ns; i = (i + 1) & 'hFFFF;
    end
    e_idx = i; e_pix = p; e_met = m; e_cnt = c;
  endtask

  // memory responder: latency depends on address
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid = 1'b0; wcnt = 0;
    end else if (mem_valid) begin
      mem_valid = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt == 0) req_addr = int'(mem_addr);
      if (wcnt >= int'(mem_addr) % 3) begin
        chk(int'(mem_addr) == req_addr, "R13", int'(mem_addr), req_addr);
        mem_valid = 1'b1;
        if (mem_we) begin
          if (q_wa.size() == 0) chk(0, "R11", int'(mem_addr), -1);
          else begin
            chk(int'(mem_addr) == q_wa[0] && int'(mem_wdata) == q_wd[0], "R11",
                int'({mem_addr, mem_wdata}), (q_wa[0] << 16) | q_wd[0]);
            void'(q_wa.pop_front()); void'(q_wd.pop_front());
          end
          mem[mem_addr[11:0]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[11:0]];
        end
      end else wcnt++;
    end
  end

  // copy engine responder
  always @(negedge clk) begin
    if (!rst_n) begin
      copy_done = 1'b0; bcnt = 0;
    end else if (copy_done) begin
      copy_done = 1'b0;
    end else if (blit_req) begin
      if (bcnt == 0) begin
        cap_s = int'(b_src); cap_d = int'(b_dw);
        if (q_bs.size() == 0) chk(0, "R7", cap_s, -1);
        else begin
          chk(cap_s == q_bs[0] && cap_d == q_bd[0] && int'(b_bit) == q_bb[0]
              && int'(b_w) == q_bw[0], "R7",
              int'({b_src, b_dw}), (q_bs[0] << 16) | q_bd[0]);
          void'(q_bs.pop_front()); void'(q_bd.pop_front());
          void'(q_bb.pop_front()); void'(q_bw.pop_front());
        end
      end
      bcnt++;
      if (bcnt == 3) begin
        chk(int'(b_src) == cap_s && int'(b_dw) == cap_d && !mem_req, "R8",
            int'(b_src), cap_s);
        copy_done = 1'b1; bcnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL R12 watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input int md, input int idx, input int last, input int pix,
                     input int met, input int cnt, input int margin, input int space);
    int n;
    string sl;
    model(md, idx, last, pix, met, cnt, margin, space);
    @(negedge clk);
    mode = 2'(md); idx_in = 16'(idx); last_in = 16'(last); pix_in = 16'(pix);
    met_in = 16'(met); cnt_in = 16'(cnt); margin_in = 16'(margin); space_in = 16'(space);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    if (!done) chk(0, "R12", 0, 1);
    else begin
      sl = (e_stat == 0) ? "R2" : ((e_stat == 1) ? "R6" : "R4");
      chk(int'(status) == e_stat, sl, int'(status), e_stat);
      chk(int'(idx_out) == e_idx, "R9", int'(idx_out), e_idx);
      chk(int'(pix_out) == e_pix, "R5,R10", int'(pix_out), e_pix);
      chk(int'(met_out) == e_met, "R3,R9", int'(met_out), e_met);
      chk(int'(cnt_out) == e_cnt, "R10", int'(cnt_out), e_cnt);
    end
    @(negedge clk);
    chk(!done && !mem_req && !blit_req && int'(idx_out) == e_idx, "R12",
        int'({done, mem_req, blit_req}), 0);
    chk(q_wa.size() + q_bs.size() == 0, "R7,R11", q_wa.size() + q_bs.size(), 0);
    q_wa.delete(); q_wd.delete(); q_bs.delete(); q_bd.delete(); q_bb.delete(); q_bw.delete();
  endtask

  initial begin
    int txt[9];
    txt = '{'h48, 'h69, 'h20, 'h79, 'h6F, 'h20, 'h75, 'h5A, 'h71};
    for (int a = 0; a < 4096; a++) mem[a] = '0;
    for (int c = 0; c < 256; c++) begin
      mem[FB + 2 * c]     = 16'(((c & 3) << 14) | ((c * 5) & 'h3FFF));
      mem[FB + 2 * c + 1] = 16'(100 + (c % 17) * 10);
    end
    for (int k = 0; k < 128; k++) mem[FB + 512 + k] = 16'((pwf(2 * k) << 8) | pwf(2 * k + 1));
    for (int k = 0; k < 9; k++) begin
      if (k % 2 == 0) mem[TB + k / 2] = 16'(txt[k] << 8);
      else mem[TB + k / 2] = 16'(rd(TB + k / 2) | txt[k]);
    end
    set_flag('h20, 2);
    set_flag('h5A, 1);
    set_flag('h21, 1);

    rst_n = 1'b0; start = 1'b0; mode = '0; idx_in = '0; last_in = '0; pix_in = '0;
    met_in = '0; cnt_in = '0; margin_in = '0; space_in = '0;
    mem_valid = 1'b0; copy_done = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !blit_req, "R1", int'({done, mem_req, blit_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req && !blit_req, "R1", int'({done, mem_req, blit_req}), 0);

    run(0, 0, 6, 10, 0, -1, 'hFFFF, 4);        // display with pads, R7 R10
    run(1, 0, 6, 10, 0, -1, 'hFFFF, 4);        // format: pads gain no space
    run(2, 1, 8, 3, 0, -1, 'hFFFF, 5);         // resolve, stops at index 7, R11 R4
    run(0, 0, 6, 0, 0, 0, 300, 2);             // margin hit, R6
    run(1, 3, 4, 0, 'h8000, 0, 'hF000, 1);     // unsigned margin above sign bit
    run(0, 5, 4, 7, 9, 3, 'hFFFF, 1);          // empty range, R2
    run(0, 3, 5, 5, 20, -2, 'hFFFF, 6);        // odd start, kern and bit offset
    run(2, 0, 2, 17, 0, 0, 'hFFFF, 3);         // resolve, non-negative count
    run(1, 2, 2, 0, 'hFFFF, 0, 'hFFFF, 0);     // metric sum wraps below margin

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule